// File: doc/BRIEF.md
# Self-Correcting JK Sequence Generator

This block is a synchronous three-bit state machine that steps through the decimal values 1, 3, 4 and 7 and then starts again. Each state bit is held in its own JK-style storage element. A small set of excitation terms decides, for every stage, whether that stage holds, sets, clears or toggles. All three stages share one clock edge, so the whole state updates at the same time.

The four codes outside the cycle (0, 2, 5 and 6) are not trapped states. Each of them moves to a legal code on the next enabled clock, and the machine then stays in the cycle. A count-enable input pauses the machine without losing its place. A registered wrap output marks each completed lap. A seed-load input lets the surrounding logic, or a test, place any code in the state directly. This is how the unused codes can be reached at all.

Top module: `jk_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 3'b001 and `wrap` becomes 0 on that edge. `rst` takes priority over every other input.
- R2: With `en` high, and `rst` and `load` low, the state advances on each rising edge along 001 → 011 → 100 → 111 → 001. The output therefore reads 1, 3, 4, 7 and then repeats.
- R3: With `en`, `rst` and `load` all low, the state keeps its value, whatever that value is, and `wrap` is 0.
- R4: With `en` high, an unused code moves on the next edge as follows: 000 → 001, 010 → 011, 101 → 111, 110 → 111.
- R5: `wrap` is 1 for exactly the one clock period that follows an enabled edge on which the state went from 111 to 001. In every other cycle it is 0.
- R6: With `load` high and `rst` low, the state takes the value of `seed` on the next edge whatever `en` is, and `wrap` becomes 0.
- R7: Once the state is one of 001, 011, 100 or 111, enabled edges never take it out of that set.
- R8: Each stage follows JK rules under the excitation J2 = K2 = s1·s0, J1 = s0 + s2, K1 = s0, J0 = 1, K0 = ¬s2·s1, where s2 is the MSB of `state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous active-high reset to code 001 |
| en | input | 1 | Count enable; when low, all stages hold |
| load | input | 1 | Synchronous seed load; overrides `en` |
| seed | input | 3 | Code written into the state when `load` is high |
| state | output | 3 | Current code, MSB first |
| wrap | output | 1 | One-cycle pulse after the 7 → 1 step |

## Verification
The hardest situations to reach from the ports are the four unused codes, because no sequence of reset and enable ever produces them. The bench places each of them in the state through the seed load and then gives one enabled clock, which shows the recovery target. It keeps clocking after that to confirm the state stays in the cycle. It also holds an unused code with `en` low, to show that a paused machine keeps even an illegal value. A behavioural model built from a list of the cycle and a recovery lookup is compared with both outputs on every clock.

// File: rtl/jk_seq_gen.sv
module jk_seq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic [2:0] seed,
  output logic [2:0] state,
  output logic       wrap
);
  localparam int N = 3;

  logic [N-1:0] q, jx, kx, j, k;
  logic s2, s1, s0;

  assign {s2, s1, s0} = q;
  assign state = q;

  // excitation terms (R8)
  assign jx = {s1 & s0, s0 | s2, 1'b1};
  assign kx = {s1 & s0, s0, ~s2 & s1};
  assign j  = en ? jx : '0;
  assign k  = en ? kx : '0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic ff;
    always_ff @(posedge clk) begin
      if (rst)       ff <= (i == 0) ? 1'b1 : 1'b0;
      else if (load) ff <= seed[i];
      else begin
        case ({j[i], k[i]})
          2'b10:   ff <= 1'b1;
          2'b01:   ff <= 1'b0;
          2'b11:   ff <= ~ff;
          default: ff <= ff;
        endcase
      end
    end
    assign q[i] = ff;
  end

  always_ff @(posedge clk) begin
    if (rst || load) wrap <= 1'b0;
    else             wrap <= en && (q == 3'b111);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (state == 3'b001 && !wrap));

  p_step_1_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b001) |=> state == 3'b011);
  p_step_3_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b011) |=> state == 3'b100);
  p_step_4_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b100) |=> state == 3'b111);
  p_step_7_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b111) |=> state == 3'b001);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(state) && !wrap));

  p_fix_0_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b000) |=> state == 3'b001);
  p_fix_2_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 3'b010) |=> state == 3'b011);
  p_fix_5_6_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !load && (state == 3'b101 || state == 3'b110)) |=> state == 3'b111);

  p_wrap_cause_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (state == 3'b001 && $past(state) == 3'b111));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (state == $past(seed) && !wrap));

  p_closed_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !load && (state == 3'b001 || state == 3'b011 ||
                     state == 3'b100 || state == 3'b111))
    |=> (state == 3'b001 || state == 3'b011 ||
         state == 3'b100 || state == 3'b111));
endmodule

// File: tb/sim_jk_seq_gen.sv
module sim_jk_seq_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [2:0] seed = 3'b000;
  logic [2:0] state;
  logic wrap;

  int total = 0, bad = 0;
  int exp_state = 1, exp_wrap = 0;
  int lap[$] = '{1, 3, 4, 7};

  always #(PERIOD / 2) clk = ~clk;

  jk_seq_gen u0 (.clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
                 .state(state), .wrap(wrap));

  function automatic int next_code(int cur);
    int hit[$];
    hit = lap.find_first_index(x) with (x == cur);
    if (hit.size() != 0) return lap[(hit[0] + 1) % lap.size()];
    case (cur)
      0: return 1;
      2: return 3;
      default: return 7;
    endcase
  endfunction

  function automatic bit in_lap(int cur);
    int hit[$];
    hit = lap.find_first_index(x) with (x == cur);
    return hit.size() != 0;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit e, bit l, int s);
    @(negedge clk);
    rst = r; en = e; load = l; seed = 3'(s);
    @(posedge clk);
    if (r) begin exp_state = 1; exp_wrap = 0; end
    else if (l) begin exp_state = s; exp_wrap = 0; end
    else if (e) begin exp_wrap = (exp_state == 7); exp_state = next_code(exp_state); end
    else exp_wrap = 0;
    #1;
    check(tag, int'(state), exp_state, "state");
    check(tag, int'(wrap), exp_wrap, "wrap");
  endtask

  initial begin
    #(PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step("R1", 1, 0, 0, 0);
    step("R1", 1, 1, 1, 5);
    // R2 and R5: several full laps
    for (int n = 0; n < 10; n++) step("R2", 0, 1, 0, 0);
    // R3: pause, including while at 7
    for (int n = 0; n < 3; n++) step("R3", 0, 0, 0, 0);
    while (exp_state != 7) step("R2", 0, 1, 0, 0);
    for (int n = 0; n < 3; n++) step("R3", 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0);
    step("R5", 0, 1, 0, 0);
    // R4 and R7: each unused code
    foreach (lap[m]) begin end
    for (int u = 0; u < 8; u++) begin
      if (in_lap(u)) continue;
      step("R6", 0, 0, 1, u);
      step("R3", 0, 0, 0, 0);
      step("R4", 0, 1, 0, 0);
      for (int n = 0; n < 6; n++) begin
        step("R7", 0, 1, 0, 0);
        check("R7", int'(in_lap(int'(state))), 1, "in_cycle");
      end
    end
    // R6: load with en high, and of legal codes
    step("R6", 0, 1, 1, 4);
    step("R8", 0, 1, 0, 0);
    step("R6", 0, 1, 1, 7);
    step("R8", 0, 1, 0, 0);
    step("R6", 0, 0, 1, 3);
    step("R8", 0, 1, 0, 0);
    // R1: reset in the middle of a run
    step("R1", 1, 1, 0, 0);
    for (int n = 0; n < 5; n++) step("R2", 0, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule